// File: doc/BRIEF.md
# Serial Byte Transmitter with Selectable Bit Rate

This block turns one 8-bit byte into an asynchronous serial frame on a single output line. A producer offers a byte with a valid/ready handshake. Once the byte is taken, the line goes low for a start bit, carries the eight data bits least significant first, then goes high for a stop bit. The line rests high between frames.

The length of one bit is a whole number of clock cycles, picked by a 2-bit rate select from four fixed divisors. With a 50 MHz clock the defaults give roughly 2400, 4800, 9600 and 19200 bits per second. Both the rate select and the byte are captured when the byte is taken, so the producer may change them while a frame is on the line. Because `in_ready` rises in the last cycle of the stop bit, a waiting byte starts the next frame with no idle gap.

A sequencer with five states runs each frame. The states are idle, start, delay, shift and stop. The shift state lasts exactly one cycle and always hands back to the delay state. The delay state waits out the rest of the current bit.

Top module: `uart_serializer`

## Requirements
- R1: While `rst_n` is low, including a reset in the middle of a frame, `txd` is 1, `busy` is 0 and `in_ready` is 1. These values hold until a byte is accepted.
- R2: A byte is taken only on a rising clock edge where `in_valid` and `in_ready` are both 1. From that edge on, `txd` is 0. While `in_valid` is 0 in idle, `txd` stays 1 and `busy` stays 0, whatever `in_data` and `baud_sel` hold.
- R3: A frame is, in order: one start bit at 0, then `in_data[0]` through `in_data[7]`, then one stop bit at 1.
- R4: Each of the ten bits lasts exactly P clock cycles, where P is the selected divisor. `txd` comes straight from a register and changes only on the clock edge that ends a bit.
- R5: `baud_sel` values 0, 1, 2 and 3 select P = `BAUD_DIV0`, `BAUD_DIV1`, `BAUD_DIV2` and `BAUD_DIV3`. The defaults are 20833, 10416, 5208 and 2604, and each divisor must be at least 2. A frame lasts 10·P cycles.
- R6: `baud_sel` and `in_data` are sampled only at acceptance. Changing them during a frame does not alter that frame's levels or timing.
- R7: `in_ready` is 0 from the acceptance edge up to the last cycle of the stop bit, and is 1 in that last cycle. A byte offered there starts its start bit right after the stop bit, with no idle cycle in between.
- R8: `busy` is 1 from the acceptance edge until the stop bit ends. It is 0 in idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block can take a byte in this cycle |
| in_data | input | 8 | Byte to send |
| baud_sel | input | 2 | Selects the bit-length divisor |
| txd | output | 1 | Serial output line, high when idle |
| busy | output | 1 | A frame is in progress |

## Verification
Two things can happen in the same cycle: a frame finishes its stop bit, and a new byte is accepted. The bench provokes this by raising `in_valid` with a fresh byte and rate exactly in the final stop cycle, while `in_ready` is high. Several chained frames are sent in a row this way. It then checks that the line drops to the start bit on the very next edge, that `busy` never falls, and that the new frame uses the new divisor. Every other frame is sent with an idle gap instead, so both ways of leaving the stop state are compared cycle by cycle against frame levels computed in the bench.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int unsigned DATA_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DELAY = 3'd2,
    ST_SHIFT = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_t;

  // Bit length in cycles for a rate select value.
  function automatic int unsigned pick_divisor(input logic [1:0] sel,
                                               input int unsigned d0,
                                               input int unsigned d1,
                                               input int unsigned d2,
                                               input int unsigned d3);
    int unsigned r;
    case (sel)
      2'd0:    r = d0;
      2'd1:    r = d1;
      2'd2:    r = d2;
      default: r = d3;
    endcase
    return r;
  endfunction

  function automatic int unsigned max_of4(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned c,
                                          input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] period_in,
  input  logic             run,
  output logic             bit_end
);

  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt_q;

  assign bit_end = run && (cnt_q == period_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '1;
      cnt_q    <= '0;
    end else if (load) begin
      period_q <= period_in;
      cnt_q    <= '0;
    end else if (run) begin
      cnt_q <= bit_end ? '0 : cnt_q + CNT_W'(1);
    end else begin
      cnt_q <= '0;
    end
  end

  // R6
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> $stable(period_q));

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < period_q));

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] data_in,
  input  logic         shift,
  output logic         lsb,
  output logic         all_sent
);

  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] sent_q;

  assign lsb      = sh_q[0];
  assign all_sent = (sent_q == CW'(W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      sent_q <= '0;
    end else if (load) begin
      sh_q   <= data_in;
      sent_q <= '0;
    end else if (shift) begin
      sh_q   <= {1'b0, sh_q[W-1:1]};
      sent_q <= sent_q + CW'(1);
    end
  end

  // R3
  no_overshift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (sent_q < CW'(W)));

endmodule

// File: rtl/tx_sequencer.sv
module tx_sequencer
  import uart_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic bit_end,
  input  logic lsb,
  input  logic all_sent,
  output logic in_ready,
  output logic accept,
  output logic shift_en,
  output logic run,
  output logic txd,
  output logic busy
);

  tx_state_t state_q, state_d;
  logic      txd_q, txd_d;

  assign in_ready = (state_q == ST_IDLE) || ((state_q == ST_STOP) && bit_end);
  assign accept   = in_valid && in_ready;
  assign shift_en = (state_q == ST_SHIFT);
  assign run      = (state_q != ST_IDLE);
  assign busy     = run;
  assign txd      = txd_q;

  always_comb begin
    state_d = state_q;
    txd_d   = txd_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_START;
          txd_d   = 1'b0;
        end
      end
      ST_START: begin
        if (bit_end) begin
          state_d = ST_SHIFT;
          txd_d   = lsb;
        end
      end
      ST_SHIFT: begin
        state_d = ST_DELAY;
      end
      ST_DELAY: begin
        if (bit_end) begin
          if (all_sent) begin
            state_d = ST_STOP;
            txd_d   = 1'b1;
          end else begin
            state_d = ST_SHIFT;
            txd_d   = lsb;
          end
        end
      end
      ST_STOP: begin
        if (bit_end) begin
          if (accept) begin
            state_d = ST_START;
            txd_d   = 1'b0;
          end else begin
            state_d = ST_IDLE;
            txd_d   = 1'b1;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        txd_d   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      txd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      txd_q   <= txd_d;
    end
  end

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> txd_q);

  // R2
  start_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!txd_q && busy));

  // R4
  txd_only_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bit_end && !accept) |=> $stable(txd_q));

  // R3
  shift_then_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |=> (state_q == ST_DELAY));

  // R3
  stop_after_all_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |-> all_sent);

  // R7
  ready_low_mid_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DELAY) || (state_q == ST_SHIFT) || (state_q == ST_START)) |-> !in_ready);

endmodule

// File: rtl/uart_serializer.sv
module uart_serializer
  import uart_tx_pkg::*;
#(
  parameter int unsigned BAUD_DIV0 = 20833,
  parameter int unsigned BAUD_DIV1 = 10416,
  parameter int unsigned BAUD_DIV2 = 5208,
  parameter int unsigned BAUD_DIV3 = 2604
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic [1:0] baud_sel,
  output logic       txd,
  output logic       busy
);

  localparam int unsigned DIV_MAX = max_of4(BAUD_DIV0, BAUD_DIV1, BAUD_DIV2, BAUD_DIV3);
  localparam int unsigned CNT_W   = $clog2(DIV_MAX + 1);

  logic             accept;
  logic             shift_en;
  logic             run;
  logic             bit_end;
  logic             lsb;
  logic             all_sent;
  logic [CNT_W-1:0] period_sel;

  assign period_sel = CNT_W'(pick_divisor(baud_sel, BAUD_DIV0, BAUD_DIV1,
                                          BAUD_DIV2, BAUD_DIV3));

  tx_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .period_in (period_sel),
    .run       (run),
    .bit_end   (bit_end)
  );

  tx_shifter #(.W(DATA_BITS)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .data_in  (in_data),
    .shift    (shift_en),
    .lsb      (lsb),
    .all_sent (all_sent)
  );

  tx_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .bit_end  (bit_end),
    .lsb      (lsb),
    .all_sent (all_sent),
    .in_ready (in_ready),
    .accept   (accept),
    .shift_en (shift_en),
    .run      (run),
    .txd      (txd),
    .busy     (busy)
  );

endmodule

// File: tb/tb_uart_serializer.sv
`timescale 1ns/1ps
module tb_uart_serializer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic [1:0] baud_sel = 2'd0;
  logic       txd;
  logic       busy;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_serializer #(
    .BAUD_DIV0(7), .BAUD_DIV1(5), .BAUD_DIV2(3), .BAUD_DIV3(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .baud_sel(baud_sel), .txd(txd), .busy(busy)
  );

  function automatic int per(input logic [1:0] s);
    case (s)
      2'd0: return 7;
      2'd1: return 5;
      2'd2: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic logic level_at(input logic [7:0] d, input int idx);
    if (idx == 0) return 1'b0;
    if (idx == 9) return 1'b1;
    return d[idx-1];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_check(input string req);
    chk(txd == 1'b1, req, txd, 1);
    chk(busy == 1'b0, req, busy, 0);
    chk(in_ready == 1'b1, req, in_ready, 1);
  endtask

  // Called at a negedge while idle: offer the byte, step to the negedge after acceptance.
  task automatic offer(input logic [7:0] d, input logic [1:0] s);
    in_valid = 1'b1;
    in_data  = d;
    baud_sel = s;
    chk(in_ready == 1'b1, "R7 ready in idle", in_ready, 1);
    @(negedge clk);
  endtask

  // Called at the negedge right after acceptance. Checks every cycle of the frame.
  task automatic play(input logic [7:0] d, input logic [1:0] s, input bit chain,
                      input logic [7:0] nd, input logic [1:0] ns);
    int p;
    p = per(s);
    for (int n = 0; n < 10 * p; n++) begin
      int  idx;
      logic e;
      idx = n / p;
      e   = level_at(d, idx);
      if (n == 0)
        chk(txd == e, "R2 start on accept", txd, e);
      else if (n % p == 0)
        chk(txd == e, "R4 bit edge", txd, e);
      else if (n % p == p - 1)
        chk(txd == e, "R6 bit tail after input change", txd, e);
      else
        chk(txd == e, "R3 frame level", txd, e);
      chk(busy == 1'b1, "R8 busy in frame", busy, 1);
      if (n == 10 * p - 1) begin
        chk(in_ready == 1'b1, "R7 ready in last stop cycle", in_ready, 1);
        chk(busy == 1'b1, "R5 frame length", busy, 1);
      end else begin
        chk(in_ready == 1'b0, "R7 ready low mid frame", in_ready, 0);
      end
      if (n == 0) in_valid = 1'b0;
      if (n == 1) begin
        baud_sel = s + 2'd1;
        in_data  = ~d;
        in_valid = 1'b0;
      end
      if (n == 10 * p - 1 && chain) begin
        in_valid = 1'b1;
        in_data  = nd;
        baud_sel = ns;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      done = 1'b1;
      $finish;
    end
  end

  initial begin
    // Reset state
    repeat (3) @(negedge clk);
    idle_check("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1 after reset");

    // Idle with valid low: garbage on data and select is ignored
    for (int k = 0; k < 24; k++) begin
      in_data  = 8'(k * 37);
      baud_sel = 2'(k);
      @(negedge clk);
      chk(txd == 1'b1, "R2 idle ignore txd", txd, 1);
      chk(busy == 1'b0, "R2 idle ignore busy", busy, 0);
    end

    // Exhaustive byte sweep at every rate; even bytes chain into the next one
    for (int s = 0; s < 4; s++) begin
      bit chained;
      chained = 1'b0;
      for (int b = 0; b < 256; b++) begin
        bit nxt;
        logic [1:0] ns;
        nxt = (b[0] == 1'b0) && (b != 255);
        ns  = (b % 4 == 0) ? 2'(s + 1) : 2'(s);
        if (!chained) offer(8'(b), 2'(s));
        play(8'(b), chained && (b % 4 == 1) ? 2'(s + 1) : 2'(s), nxt, 8'(b + 1), ns);
        chained = nxt;
        if (!nxt) begin
          idle_check("R5 idle after frame");
        end
      end
    end

    // Reset in the middle of a frame
    offer(8'h00, 2'd0);
    repeat (25) @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    idle_check("R1 reset mid frame");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1 after mid frame reset");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule